// File: doc/BRIEF.md
# Codec Calibration and Loopback Controller

This block is the digital mode controller of a serial audio codec. It watches the block reset and the control/data mode indication. It runs an offset-calibration interval whenever the codec comes out of reset and whenever it moves from control mode into data mode. It also steers the serial frame path among three modes: normal operation, analog loopback and digital loopback. The calibration itself is modelled as a fixed number of frames. While those frames run, the block reports that calibration is busy, blocks the DAC input and sends zero in place of converter data.

The host chooses the loopback mode with two control bits, an enable and a select. The block samples them on frame strobes, so a mode change always lines up with a frame. In digital loopback the received frame word comes back on the transmit side two frames later. A short delay line provides this, and it is cleared when the mode is entered, so stale words are never echoed. The monitor-mix enable follows the host request, except that it is held off during calibration and during analog loopback.

Top module: `codec_cal_loop_ctrl`

## Requirements
- R1: A rising edge of `data_mode` (control mode to data mode) starts calibration. `cal_busy` is high on the cycle after the edge is sampled, and no other input can suppress it. A falling edge does not start calibration.
- R2: While `rst` is high, every output is zero. On the first clock after `rst` falls, calibration starts, so `cal_busy` is high one cycle later.
- R3: Calibration lasts CAL_FRAMES frame strobes counted after the trigger. `cal_busy` falls on the clock edge of the CAL_FRAMES-th strobe.
- R4: A new trigger while calibration is running restarts the count. `cal_busy` then stays high for a further CAL_FRAMES strobes.
- R5: While `cal_busy` is high, `dac_open` is low. At every strobe in that time, `dac_word` and `tx_word` load zero, so the received word and the converter word are ignored.
- R6: `mon_en` is `mon_req` delayed by one register. It is forced low while calibration runs and while analog loopback is selected.
- R7: The loopback mode is sampled only at a frame strobe. `lb_en`=0 selects normal mode, `lb_en`=1 with `lb_sel`=1 selects analog loopback, and `lb_en`=1 with `lb_sel`=0 selects digital loopback. `tx_word` and `dac_word` change only on strobe edges.
- R8: Outside calibration, in normal and analog loopback modes, each strobe loads `adc_word` into `tx_word` and `rx_word` into `dac_word`.
- R9: In digital loopback, `tx_word` loaded at strobe j equals the `rx_word` sampled at strobe j-2. On entry the delay line is cleared: the entry strobe and the next two strobes load zero, and the third strobe after entry echoes the word received at the first strobe after entry.
- R10: The DAC path keeps running in digital loopback. Each strobe outside calibration loads `rx_word` into `dac_word`, and `dac_open` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release starts calibration |
| data_mode | input | 1 | 1 = data mode, 0 = control mode |
| lb_en | input | 1 | Enable for the extra loopback modes |
| lb_sel | input | 1 | 1 = analog loopback, 0 = digital loopback (when enabled) |
| frame_sync | input | 1 | One-cycle frame boundary strobe |
| mon_req | input | 1 | Host request for the monitor mix |
| rx_word | input | FRAME_W | Frame word received from the serial input |
| adc_word | input | FRAME_W | Converter word to transmit in normal operation |
| cal_busy | output | 1 | Calibration in progress |
| dac_open | output | 1 | DAC input accepted |
| dac_word | output | FRAME_W | Word passed to the DAC |
| mon_en | output | 1 | Monitor mix enable |
| tx_word | output | FRAME_W | Frame word sent on the serial output |

## Verification
The bench builds the block with FRAME_W=16, CAL_FRAMES=5 and ECHO_FRAMES=2. A five-frame calibration is short enough that random runs often retrigger in the middle of a count, reset in the middle of a count, and change loopback mode just as calibration ends. A 16-bit word keeps the echoed values easy to tell apart. The two-stage echo depth exposes the zero-fill on entry and the exact frame on which the first valid echo appears.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

  typedef enum logic [1:0] {
    LB_OFF     = 2'd0,
    LB_ANALOG  = 2'd1,
    LB_DIGITAL = 2'd2
  } lb_mode_e;

  function automatic lb_mode_e lb_decode(input logic en, input logic sel);
    if (!en)      return LB_OFF;
    else if (sel) return LB_ANALOG;
    else          return LB_DIGITAL;
  endfunction

endpackage

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
  parameter int CAL_FRAMES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic data_mode,
  input  logic frame_sync,
  output logic busy_q,
  output logic busy_nxt
);
  localparam int CNT_W = (CAL_FRAMES > 1) ? $clog2(CAL_FRAMES + 1) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CAL_FRAMES - 1);

  logic             released_q;
  logic             mode_prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             trigger;

  // previous mode sample, deliberately not reset so entry edges are seen at once
  always_ff @(posedge clk) mode_prev_q <= data_mode;

  assign trigger = !released_q || (data_mode && !mode_prev_q);

  always_comb begin
    busy_nxt = busy_q;
    cnt_nxt  = cnt_q;
    if (trigger) begin
      busy_nxt = 1'b1;
      cnt_nxt  = '0;
    end else if (busy_q && frame_sync) begin
      if (cnt_q == LAST) busy_nxt = 1'b0;
      else               cnt_nxt  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      released_q <= 1'b0;
      busy_q     <= 1'b0;
      cnt_q      <= '0;
    end else begin
      released_q <= 1'b1;
      busy_q     <= busy_nxt;
      cnt_q      <= cnt_nxt;
    end
  end
endmodule

// File: rtl/lb_mode_ctrl.sv
module lb_mode_ctrl
  import codec_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     frame_sync,
  input  logic     lb_en,
  input  logic     lb_sel,
  output lb_mode_e mode_q,
  output lb_mode_e mode_nxt,
  output logic     dig_entry
);
  always_comb begin
    mode_nxt = mode_q;
    if (frame_sync) mode_nxt = lb_decode(lb_en, lb_sel);
  end

  assign dig_entry = frame_sync && (mode_nxt == LB_DIGITAL) && (mode_q != LB_DIGITAL);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= LB_OFF;
    else     mode_q <= mode_nxt;
  end
endmodule

// File: rtl/echo_delay.sv
module echo_delay #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         clear,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || clear) stg[0] <= '0;
        else if (shift)   stg[0] <= din;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst || clear) stg[g] <= '0;
        else if (shift)   stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/codec_cal_loop_ctrl.sv
module codec_cal_loop_ctrl
  import codec_ctl_pkg::*;
#(
  parameter int FRAME_W     = 32,
  parameter int CAL_FRAMES  = 8,
  parameter int ECHO_FRAMES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               data_mode,
  input  logic               lb_en,
  input  logic               lb_sel,
  input  logic               frame_sync,
  input  logic               mon_req,
  input  logic [FRAME_W-1:0] rx_word,
  input  logic [FRAME_W-1:0] adc_word,
  output logic               cal_busy,
  output logic               dac_open,
  output logic [FRAME_W-1:0] dac_word,
  output logic               mon_en,
  output logic [FRAME_W-1:0] tx_word
);
  logic               busy_q, busy_nxt;
  lb_mode_e           mode_q, mode_nxt;
  logic               dig_entry;
  logic [FRAME_W-1:0] echo_out;

  cal_sequencer #(.CAL_FRAMES(CAL_FRAMES)) u_cal (
    .clk       (clk),
    .rst       (rst),
    .data_mode (data_mode),
    .frame_sync(frame_sync),
    .busy_q    (busy_q),
    .busy_nxt  (busy_nxt)
  );

  lb_mode_ctrl u_mode (
    .clk       (clk),
    .rst       (rst),
    .frame_sync(frame_sync),
    .lb_en     (lb_en),
    .lb_sel    (lb_sel),
    .mode_q    (mode_q),
    .mode_nxt  (mode_nxt),
    .dig_entry (dig_entry)
  );

  echo_delay #(.W(FRAME_W), .DEPTH(ECHO_FRAMES)) u_echo (
    .clk  (clk),
    .rst  (rst),
    .shift(frame_sync),
    .clear(dig_entry),
    .din  (rx_word),
    .dout (echo_out)
  );

  assign cal_busy = busy_q;

  // flags follow the next calibration and mode state
  always_ff @(posedge clk) begin
    if (rst) begin
      dac_open <= 1'b0;
      mon_en   <= 1'b0;
    end else begin
      dac_open <= !busy_nxt;
      mon_en   <= mon_req && !busy_nxt && (mode_nxt != LB_ANALOG);
    end
  end

  // frame words move only on strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word  <= '0;
      dac_word <= '0;
    end else if (frame_sync) begin
      if (busy_q) begin
        tx_word  <= '0;
        dac_word <= '0;
      end else begin
        dac_word <= rx_word;
        if (mode_nxt == LB_DIGITAL) tx_word <= dig_entry ? '0 : echo_out;
        else                        tx_word <= adc_word;
      end
    end
  end
endmodule

// File: rtl/codec_cal_loop_ctrl_chk.sv
module codec_cal_loop_ctrl_chk #(
  parameter int FRAME_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               data_mode,
  input logic               lb_en,
  input logic               frame_sync,
  input logic               mon_req,
  input logic [FRAME_W-1:0] adc_word,
  input logic               cal_busy,
  input logic [FRAME_W-1:0] dac_word,
  input logic               mon_en,
  input logic [FRAME_W-1:0] tx_word
);
  a_r1_entry_starts_cal: assert property (@(posedge clk) disable iff (rst)
    (data_mode && !$past(data_mode)) |=> cal_busy);

  a_r2_release_starts_cal: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> cal_busy);

  a_r5_cal_blocks_words: assert property (@(posedge clk) disable iff (rst)
    (cal_busy && frame_sync) |=> (dac_word == '0 && tx_word == '0));

  a_r6_mon_forced_off: assert property (@(posedge clk) disable iff (rst)
    mon_en |-> (!cal_busy && $past(mon_req)));

  a_r7_words_frame_aligned: assert property (@(posedge clk) disable iff (rst)
    !frame_sync |=> ($stable(tx_word) && $stable(dac_word)));

  a_r8_normal_sends_adc: assert property (@(posedge clk) disable iff (rst)
    (frame_sync && !lb_en && !cal_busy) |=> (tx_word == $past(adc_word)));
endmodule

bind codec_cal_loop_ctrl codec_cal_loop_ctrl_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .data_mode (data_mode),
  .lb_en     (lb_en),
  .frame_sync(frame_sync),
  .mon_req   (mon_req),
  .adc_word  (adc_word),
  .cal_busy  (cal_busy),
  .dac_word  (dac_word),
  .mon_en    (mon_en),
  .tx_word   (tx_word)
);

// File: tb/tb_codec_cal_loop_ctrl.sv
module tb_codec_cal_loop_ctrl;
  localparam int W   = 16;
  localparam int CAL = 5;

  logic clk = 1'b0;
  logic rst = 1'b1, data_mode = 1'b0, lb_en = 1'b0, lb_sel = 1'b0;
  logic frame_sync = 1'b0, mon_req = 1'b0;
  logic [W-1:0] rx_word = '0, adc_word = '0;
  logic cal_busy, dac_open, mon_en;
  logic [W-1:0] dac_word, tx_word;

  always #5 clk = ~clk;

  codec_cal_loop_ctrl #(.FRAME_W(W), .CAL_FRAMES(CAL), .ECHO_FRAMES(2)) dut (
    .clk(clk), .rst(rst), .data_mode(data_mode), .lb_en(lb_en), .lb_sel(lb_sel),
    .frame_sync(frame_sync), .mon_req(mon_req), .rx_word(rx_word), .adc_word(adc_word),
    .cal_busy(cal_busy), .dac_open(dac_open), .dac_word(dac_word), .mon_en(mon_en),
    .tx_word(tx_word)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state (modes: 0 normal, 1 analog, 2 digital)
  bit m_rel, m_busy, m_dmprev, m_open, m_mon, pre_busy;
  int m_cnt, m_mode, pre_mode;
  logic [W-1:0] m_d1, m_d2, m_tx, m_dac;

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_step();
    bit trig, entry;
    int mode_n;
    pre_busy = m_busy;
    pre_mode = m_mode;
    if (rst) begin
      m_rel = 0; m_busy = 0; m_cnt = 0; m_mode = 0;
      m_d1 = '0; m_d2 = '0; m_tx = '0; m_dac = '0; m_open = 0; m_mon = 0;
    end else begin
      trig   = !m_rel || (data_mode && !m_dmprev);
      mode_n = frame_sync ? (!lb_en ? 0 : (lb_sel ? 1 : 2)) : m_mode;
      entry  = frame_sync && mode_n == 2 && m_mode != 2;
      if (frame_sync) begin
        if (m_busy) begin m_tx = '0; m_dac = '0; end
        else begin
          m_dac = rx_word;
          m_tx  = (mode_n == 2) ? (entry ? '0 : m_d2) : adc_word;
        end
        if (entry) begin m_d1 = '0; m_d2 = '0; end
        else begin m_d2 = m_d1; m_d1 = rx_word; end
      end
      if (trig) begin m_busy = 1; m_cnt = 0; end
      else if (m_busy && frame_sync) begin
        if (m_cnt == CAL - 1) m_busy = 0; else m_cnt++;
      end
      m_mode = mode_n;
      m_open = !m_busy;
      m_mon  = mon_req && !m_busy && mode_n != 1;
      m_rel  = 1;
    end
    m_dmprev = data_mode;
  endtask

  task automatic compare_all();
    string ttag, dtag;
    ttag = pre_busy ? "R5 tx" : (m_mode == 2 ? "R9 tx" : "R8 tx");
    dtag = pre_busy ? "R5 dac" : (m_mode == 2 ? "R10 dac" : "R8 dac");
    chk("R3 cal_busy", W'(cal_busy), W'(m_busy));
    chk("R5 dac_open", W'(dac_open), W'(m_open));
    chk("R6 mon_en", W'(mon_en), W'(m_mon));
    chk(ttag, tx_word, m_tx);
    chk(dtag, dac_word, m_dac);
  endtask

  task automatic cyc(input bit fs);
    frame_sync = fs;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    frame_sync = 1'b0;
  endtask

  task automatic frame(input int len);
    cyc(1'b1);
    for (int i = 1; i < len; i++) cyc(1'b0);
  endtask

  task automatic new_data();
    rx_word  = W'($urandom);
    adc_word = W'($urandom);
  endtask

  initial begin
    void'($urandom(32'hC0DEC5));
    @(negedge clk);
    // reset state (R2)
    repeat (3) cyc(1'b0);
    chk("R2 reset busy", W'(cal_busy), '0);
    chk("R2 reset tx", tx_word, '0);
    chk("R2 reset open", W'(dac_open), '0);
    // release starts calibration (R2), duration (R3)
    rst = 1'b0;
    cyc(1'b0);
    cyc(1'b0);
    chk("R2 busy after release", W'(cal_busy), 1);
    for (int k = 1; k <= CAL; k++) begin
      new_data();
      frame(3);
      chk("R3 duration", W'(cal_busy), (k < CAL) ? 1 : 0);
    end
    // mode entry triggers (R1), falling edge does not
    data_mode = 1'b1;
    cyc(1'b0);
    chk("R1 entry trigger", W'(cal_busy), 1);
    for (int k = 0; k < CAL; k++) frame(3);
    data_mode = 1'b0;
    cyc(1'b0); cyc(1'b0);
    chk("R1 no trigger on exit", W'(cal_busy), 0);
    // retrigger restarts count (R4)
    data_mode = 1'b1; cyc(1'b0);
    frame(3); frame(3);
    data_mode = 1'b0; cyc(1'b0);
    data_mode = 1'b1; cyc(1'b0);
    for (int k = 1; k <= CAL; k++) begin
      frame(3);
      chk("R4 restart", W'(cal_busy), (k < CAL) ? 1 : 0);
    end
    // digital loopback echo (R9, R10)
    lb_en = 1'b1; lb_sel = 1'b0;
    rx_word = 16'hA000; frame(3);
    rx_word = 16'hA001; frame(3);
    chk("R9 entry zero", tx_word, '0);
    rx_word = 16'hA002; frame(3);
    chk("R9 second zero", tx_word, '0);
    chk("R10 dac runs", dac_word, 16'hA002);
    rx_word = 16'hA003; frame(3);
    chk("R9 first echo", tx_word, 16'hA001);
    rx_word = 16'hA004; frame(3);
    chk("R9 next echo", tx_word, 16'hA002);
    // mode change waits for a strobe (R7)
    mon_req = 1'b1; cyc(1'b0);
    lb_sel = 1'b1;
    cyc(1'b0); cyc(1'b0);
    chk("R7 mid-frame no change", W'(mon_en), 1);
    chk("R7 tx held", tx_word, 16'hA002);
    frame(3);
    chk("R7 analog at strobe", W'(mon_en), 0);
    // random phase
    for (int f = 0; f < 400; f++) begin
      new_data();
      if ($urandom_range(19) == 0) data_mode = ~data_mode;
      if ($urandom_range(7) == 0) begin lb_en = 1'($urandom); lb_sel = 1'($urandom); end
      if ($urandom_range(5) == 0) mon_req = ~mon_req;
      if ($urandom_range(99) == 0) begin rst = 1'b1; cyc(1'b0); cyc(1'b0); rst = 1'b0; end
      frame(int'($urandom_range(6, 2)));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule